// File: doc/BRIEF.md
# Guard-Bit Multiply-Accumulate Unit

A single-accumulator multiply-accumulate engine for a fixed-point DSP datapath. Each cycle it accepts an opcode, a signed/unsigned select and two 16-bit operands. The operands are multiplied, and the product is held in one register stage. The following stage applies the operation to a 40-bit accumulator. The accumulator has 32 product bits and 8 guard bits above them, so long sums can grow past the 32-bit product range without wrapping.

Besides multiply and multiply-accumulate, the unit provides several other operations:
- Partial reads and writes of every accumulator field, so the whole 40-bit state can be saved and restored across a context switch.
- A fractional read window.
- A round-then-saturate operation that reduces the accumulator to a 16-bit fractional value.
- Arithmetic power-of-two scaling.

Zero, negative, overflow and carry flags follow every operation that writes the accumulator. A sticky overflow bit remembers any overflow of the full 40-bit register until the accumulator is cleared. Read results appear on a registered 16-bit output.

Top module: `dsp_mac`

## Requirements
- R1: While reset is active and after it is released, the accumulator, the read word and all five flags are zero.
- R2: Opcode 2 (MUL) places the product opa×opb in the accumulator. The product is extended to 40 bits: sign-extended when `is_signed`=1 (both operands two's complement) and zero-extended when `is_signed`=0. Results appear at the outputs on the second rising edge after the opcode is presented.
- R3: Opcode 3 (MAC) adds the extended product to the accumulator modulo 2^40. MAC opcodes issued on consecutive cycles all accumulate.
- R4: Opcode 1 (CLR) sets the accumulator to zero, sets Z=1, clears N, V and C, and clears the sticky flag.
- R5: Opcode 0 (NOP), the read opcodes 5–8 and the unused codes 19–31 leave the accumulator and all flags unchanged. Only the read opcodes change the read word.
- R6: The read opcodes load `rd_data` as follows:
  - Code 5 loads acc[31:16].
  - Code 6 loads acc[15:0].
  - Code 7 loads acc[39:32], sign-extended to 16 bits.
  - Code 8 (fractional window) loads acc[30:15].
- R7: Partial load opcodes write one field and leave the other bits unchanged:
  - Code 9 writes opa into acc[31:16].
  - Code 10 writes opa into acc[15:0].
  - Code 11 writes opa[7:0] into acc[39:32].
- R8: Whole-accumulator load opcodes, with s = opa[15]:
  - Code 12 loads {8×s, opa, 16'h0}.
  - Code 13 loads {9×s, opa, 15'h0}.
  - Code 14 loads {8×s, opa, opb}.
- R9: Opcode 4 (SATRND) adds 2^15 to the accumulator and takes bits [31:16] as the result word. If the rounded value is outside the signed 32-bit range, the word is 16'h7FFF (positive) or 16'h8000 (negative), and V=1. The accumulator becomes {8×w[15], w, 16'h0}.
- R10: Scaling opcodes shift the accumulator arithmetically, and C receives the last bit shifted out:
  - Codes 15 and 16 shift right by 1 and by 2, filling with the sign bit.
  - Codes 17 and 18 shift left by 1 and by 2. V=1 when the scaled value leaves the signed 40-bit range.
- R11: After every accumulator write, Z = (acc==0) and N = acc[39]. V is set only by MAC signed 40-bit overflow, by left scaling overflow or by SATRND saturation; C is set only by the MAC carry out of bit 39 or a scaling shift-out. Otherwise V and C are cleared.
- R12: The sticky flag is set by a MAC or left-scaling overflow of the 40-bit accumulator. SATRND saturation does not set it. It stays set through all other operations until CLR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op | input | 5 | Operation code |
| is_signed | input | 1 | 1: operands are two's complement; 0: unsigned |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| rd_data | output | 16 | Registered read word |
| flag_z | output | 1 | Accumulator is zero |
| flag_n | output | 1 | Accumulator is negative |
| flag_v | output | 1 | Overflow of the last writing operation |
| flag_c | output | 1 | Carry or shifted-out bit of the last writing operation |
| flag_sticky | output | 1 | Accumulated 40-bit overflow since the last clear |

## Verification
A corrupted accumulator shows on Z and N on the edge that writes it, two cycles after the opcode is issued. The bad value itself becomes visible only when a read opcode brings a field out, so the bench reads the three save fields often during random traffic and after every directed case. A wrong product extension or a wrong guard-bit field stays hidden in the upper byte until the guard read or SATRND exposes it. A lost sticky bit appears only after an overflow has been followed by operations that are not CLR.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_CLR     = 5'd1,
    OP_MUL     = 5'd2,
    OP_MAC     = 5'd3,
    OP_SATRND  = 5'd4,
    OP_RD_HI   = 5'd5,
    OP_RD_LO   = 5'd6,
    OP_RD_GRD  = 5'd7,
    OP_RD_FRAC = 5'd8,
    OP_LD_HI   = 5'd9,
    OP_LD_LO   = 5'd10,
    OP_LD_GRD  = 5'd11,
    OP_LD_HISX = 5'd12,
    OP_LD_FRAC = 5'd13,
    OP_LD_BOTH = 5'd14,
    OP_SHR1    = 5'd15,
    OP_SHR2    = 5'd16,
    OP_SHL1    = 5'd17,
    OP_SHL2    = 5'd18
  } mac_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } mac_flags_t;
endpackage

// File: rtl/dsp_mac_mul.sv
module dsp_mac_mul
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  mac_op_e                          op_i,
  input  logic                             sgn_i,
  input  logic [DATA_W-1:0]                opa_i,
  input  logic [DATA_W-1:0]                opb_i,
  output mac_op_e                          op_q,
  output logic [DATA_W-1:0]                opa_q,
  output logic [DATA_W-1:0]                opb_q,
  output logic [2*DATA_W+GUARD_W-1:0]      prod_q
);
  localparam int ACC_W  = 2*DATA_W + GUARD_W;
  localparam int PROD_W = 2*DATA_W + 2;

  logic signed [DATA_W:0]   a_x, b_x;
  logic signed [PROD_W-1:0] prod_full;
  logic [ACC_W-1:0]         prod_d;
  logic                     cap_en;

  // one extra bit per operand lets a single signed multiplier serve both modes
  assign a_x       = {sgn_i & opa_i[DATA_W-1], opa_i};
  assign b_x       = {sgn_i & opb_i[DATA_W-1], opb_i};
  assign prod_full = a_x * b_x;
  assign prod_d    = {{(ACC_W-PROD_W){prod_full[PROD_W-1]}}, prod_full};
  assign cap_en    = (op_i != OP_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NOP;
      opa_q  <= '0;
      opb_q  <= '0;
      prod_q <= '0;
    end else begin
      op_q <= op_i;
      if (cap_en) begin
        opa_q  <= opa_i;
        opb_q  <= opb_i;
        prod_q <= prod_d;
      end
    end
  end
endmodule

// File: rtl/dsp_mac_sat.sv
module dsp_mac_sat #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic [2*DATA_W+GUARD_W-1:0] acc_i,
  output logic [2*DATA_W+GUARD_W-1:0] res_o,
  output logic                        sat_o
);
  localparam int ACC_W = 2*DATA_W + GUARD_W;
  localparam int TOP_W = ACC_W - (2*DATA_W-1) + 1;
  localparam logic [ACC_W:0] HALF_LSB = (ACC_W+1)'(1) << (DATA_W-1);

  logic [ACC_W:0]      rnd;
  logic [TOP_W-1:0]    top;
  logic [DATA_W-1:0]   word;

  always_comb begin
    rnd   = {acc_i[ACC_W-1], acc_i} + HALF_LSB;
    top   = rnd[ACC_W:2*DATA_W-1];
    sat_o = !((&top) || (~|top));
    if (!sat_o)
      word = rnd[2*DATA_W-1:DATA_W];
    else if (rnd[ACC_W])
      word = {1'b1, {(DATA_W-1){1'b0}}};
    else
      word = {1'b0, {(DATA_W-1){1'b1}}};
    res_o = {{GUARD_W{word[DATA_W-1]}}, word, {DATA_W{1'b0}}};
  end

  always_comb begin
    if (sat_o) begin
      assert_sat_limit_R9: assert (res_o[2*DATA_W-2:DATA_W] == {(DATA_W-1){~res_o[2*DATA_W-1]}})
        else $error("saturated word is not a limit value");
    end
  end
endmodule

// File: rtl/dsp_mac_acc.sv
module dsp_mac_acc
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  mac_op_e                     op_q,
  input  logic [DATA_W-1:0]           opa_q,
  input  logic [DATA_W-1:0]           opb_q,
  input  logic [2*DATA_W+GUARD_W-1:0] prod_q,
  input  logic [2*DATA_W+GUARD_W-1:0] sat_res,
  input  logic                        sat_flag,
  output logic [2*DATA_W+GUARD_W-1:0] acc_q,
  output mac_flags_t                  flags_q,
  output logic                        sticky_q,
  output logic [DATA_W-1:0]           rd_q
);
  localparam int ACC_W = 2*DATA_W + GUARD_W;
  localparam int MSB   = ACC_W - 1;

  logic [ACC_W-1:0]  acc_d;
  logic [ACC_W:0]    sum;
  logic [DATA_W-1:0] rd_d;
  mac_flags_t        flags_d;
  logic              sticky_d;
  logic              acc_en, rd_en, ovf40, v_d, c_d;

  always_comb begin
    acc_d    = acc_q;
    rd_d     = rd_q;
    acc_en   = 1'b0;
    rd_en    = 1'b0;
    v_d      = 1'b0;
    c_d      = 1'b0;
    ovf40    = 1'b0;
    sum      = {1'b0, acc_q} + {1'b0, prod_q};
    unique case (op_q)
      OP_CLR:     begin acc_d = '0; acc_en = 1'b1; end
      OP_MUL:     begin acc_d = prod_q; acc_en = 1'b1; end
      OP_MAC: begin
        acc_d  = sum[ACC_W-1:0];
        c_d    = sum[ACC_W];
        v_d    = (acc_q[MSB] == prod_q[MSB]) && (sum[MSB] != acc_q[MSB]);
        ovf40  = v_d;
        acc_en = 1'b1;
      end
      OP_SATRND:  begin acc_d = sat_res; v_d = sat_flag; acc_en = 1'b1; end
      OP_RD_HI:   begin rd_d = acc_q[2*DATA_W-1:DATA_W]; rd_en = 1'b1; end
      OP_RD_LO:   begin rd_d = acc_q[DATA_W-1:0]; rd_en = 1'b1; end
      OP_RD_GRD:  begin rd_d = {{(DATA_W-GUARD_W){acc_q[MSB]}}, acc_q[MSB:2*DATA_W]}; rd_en = 1'b1; end
      OP_RD_FRAC: begin rd_d = acc_q[2*DATA_W-2:DATA_W-1]; rd_en = 1'b1; end
      OP_LD_HI:   begin acc_d[2*DATA_W-1:DATA_W] = opa_q; acc_en = 1'b1; end
      OP_LD_LO:   begin acc_d[DATA_W-1:0] = opa_q; acc_en = 1'b1; end
      OP_LD_GRD:  begin acc_d[MSB:2*DATA_W] = opa_q[GUARD_W-1:0]; acc_en = 1'b1; end
      OP_LD_HISX: begin acc_d = {{GUARD_W{opa_q[DATA_W-1]}}, opa_q, {DATA_W{1'b0}}}; acc_en = 1'b1; end
      OP_LD_FRAC: begin acc_d = {{(GUARD_W+1){opa_q[DATA_W-1]}}, opa_q, {(DATA_W-1){1'b0}}}; acc_en = 1'b1; end
      OP_LD_BOTH: begin acc_d = {{GUARD_W{opa_q[DATA_W-1]}}, opa_q, opb_q}; acc_en = 1'b1; end
      OP_SHR1:    begin acc_d = {acc_q[MSB], acc_q[MSB:1]}; c_d = acc_q[0]; acc_en = 1'b1; end
      OP_SHR2:    begin acc_d = {{2{acc_q[MSB]}}, acc_q[MSB:2]}; c_d = acc_q[1]; acc_en = 1'b1; end
      OP_SHL1: begin
        acc_d  = {acc_q[MSB-1:0], 1'b0};
        c_d    = acc_q[MSB];
        v_d    = acc_q[MSB] != acc_q[MSB-1];
        ovf40  = v_d;
        acc_en = 1'b1;
      end
      OP_SHL2: begin
        acc_d  = {acc_q[MSB-2:0], 2'b00};
        c_d    = acc_q[MSB-1];
        v_d    = !((&acc_q[MSB:MSB-2]) || (~|acc_q[MSB:MSB-2]));
        ovf40  = v_d;
        acc_en = 1'b1;
      end
      default: ;
    endcase
    flags_d = '{z: (acc_d == '0), n: acc_d[MSB], v: v_d, c: c_d};
    if (op_q == OP_CLR)
      sticky_d = 1'b0;
    else
      sticky_d = sticky_q | ovf40;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      flags_q  <= '0;
      sticky_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (acc_en) begin
        acc_q    <= acc_d;
        flags_q  <= flags_d;
        sticky_q <= sticky_d;
      end
      if (rd_en) rd_q <= rd_d;
    end
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_CLR) |=> (acc_q == '0) && !sticky_q && flags_q.z)
    else $error("clear did not empty accumulator");

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_NOP || op_q == OP_RD_HI || op_q == OP_RD_LO ||
     op_q == OP_RD_GRD || op_q == OP_RD_FRAC) |=> $stable(acc_q) && $stable(flags_q))
    else $error("non-writing op changed state");

  assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_q) |-> ($past(op_q) == OP_CLR))
    else $error("sticky flag dropped without clear");

  assert_satrnd_form_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_SATRND) |=> ((&acc_q[MSB:2*DATA_W-1]) || (~|acc_q[MSB:2*DATA_W-1])) &&
                            (acc_q[DATA_W-1:0] == '0))
    else $error("SATRND result is not a sign-extended word");
endmodule

// File: rtl/dsp_mac.sv
module dsp_mac
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        op,
  input  logic              is_signed,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_sticky
);
  localparam int ACC_W = 2*DATA_W + GUARD_W;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  mac_op_e           op_q;
  logic [DATA_W-1:0] opa_q, opb_q;
  logic [ACC_W-1:0]  prod_q, acc_q, sat_res;
  logic              sat_flag;
  mac_flags_t        flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dsp_mac_mul #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) mul_i (
    .clk(clk), .rst_n(rst_int_n), .op_i(mac_op_e'(op)), .sgn_i(is_signed),
    .opa_i(opa), .opb_i(opb), .op_q(op_q), .opa_q(opa_q), .opb_q(opb_q),
    .prod_q(prod_q)
  );

  dsp_mac_sat #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) sat_i (
    .acc_i(acc_q), .res_o(sat_res), .sat_o(sat_flag)
  );

  dsp_mac_acc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) acc_i (
    .clk(clk), .rst_n(rst_int_n), .op_q(op_q), .opa_q(opa_q), .opb_q(opb_q),
    .prod_q(prod_q), .sat_res(sat_res), .sat_flag(sat_flag), .acc_q(acc_q),
    .flags_q(flags_q), .sticky_q(flag_sticky), .rd_q(rd_data)
  );

  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
  assign flag_c = flags_q.c;

  assert_guard_sext_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_q == OP_RD_GRD) |=> ((&rd_data[DATA_W-1:GUARD_W-1]) || (~|rd_data[DATA_W-1:GUARD_W-1])))
    else $error("guard read not sign-extended");
endmodule

// File: tb/dsp_mac_tb.sv
module dsp_mac_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  op;
  logic        is_signed;
  logic [15:0] opa, opb;
  logic [15:0] rd_data;
  logic        flag_z, flag_n, flag_v, flag_c, flag_sticky;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [39:0] m_acc;
  logic [15:0] m_rd;
  logic        mz, mn, mv, mc, ms;

  always #5 clk = ~clk;

  dsp_mac dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .is_signed(is_signed), .opa(opa), .opb(opb),
    .rd_data(rd_data), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .flag_c(flag_c), .flag_sticky(flag_sticky)
  );

  function automatic string req_of(input logic [4:0] c);
    case (c)
      5'd1: return "R4";  5'd2: return "R2";  5'd3: return "R3";  5'd4: return "R9";
      5'd5, 5'd6, 5'd7, 5'd8: return "R6";
      5'd9, 5'd10, 5'd11: return "R7";
      5'd12, 5'd13, 5'd14: return "R8";
      5'd15, 5'd16, 5'd17, 5'd18: return "R10";
      default: return "R5";
    endcase
  endfunction

  function automatic logic in40(input logic signed [41:0] w);
    return (w <= 42'sh7F_FFFF_FFFF) && (w >= -42'sh80_0000_0000);
  endfunction

  task automatic model_step(input logic [4:0] c, input logic s, input logic [15:0] a, input logic [15:0] b);
    logic [39:0] nacc, pa, pb, p;
    logic [40:0] u;
    logic signed [41:0] w;
    logic [15:0] word;
    logic wr, v, cy, ov40;
    nacc = m_acc; wr = 1'b1; v = 1'b0; cy = 1'b0; ov40 = 1'b0;
    pa = s ? {{24{a[15]}}, a} : {24'd0, a};
    pb = s ? {{24{b[15]}}, b} : {24'd0, b};
    p  = pa * pb;
    case (c)
      5'd1: nacc = '0;
      5'd2: nacc = p;
      5'd3: begin
        u = {1'b0, m_acc} + {1'b0, p};
        cy = u[40]; nacc = u[39:0];
        w = $signed({{2{m_acc[39]}}, m_acc}) + $signed({{2{p[39]}}, p});
        v = !in40(w); ov40 = v;
      end
      5'd4: begin
        w = $signed({{2{m_acc[39]}}, m_acc}) + 42'sd32768;
        if (w > 42'sh7FFF_FFFF)        begin word = 16'h7FFF; v = 1'b1; end
        else if (w < -42'sh8000_0000)  begin word = 16'h8000; v = 1'b1; end
        else word = w[31:16];
        nacc = {{8{word[15]}}, word, 16'h0};
      end
      5'd5: begin wr = 1'b0; m_rd = m_acc[31:16]; end
      5'd6: begin wr = 1'b0; m_rd = m_acc[15:0]; end
      5'd7: begin wr = 1'b0; m_rd = {{8{m_acc[39]}}, m_acc[39:32]}; end
      5'd8: begin wr = 1'b0; m_rd = m_acc[30:15]; end
      5'd9:  nacc[31:16] = a;
      5'd10: nacc[15:0]  = a;
      5'd11: nacc[39:32] = a[7:0];
      5'd12: nacc = {{8{a[15]}}, a, 16'h0};
      5'd13: nacc = {{9{a[15]}}, a, 15'h0};
      5'd14: nacc = {{8{a[15]}}, a, b};
      5'd15: begin nacc = $signed(m_acc) >>> 1; cy = m_acc[0]; end
      5'd16: begin nacc = $signed(m_acc) >>> 2; cy = m_acc[1]; end
      5'd17: begin
        w = $signed({{2{m_acc[39]}}, m_acc}) <<< 1;
        nacc = w[39:0]; cy = m_acc[39]; v = !in40(w); ov40 = v;
      end
      5'd18: begin
        w = $signed({{2{m_acc[39]}}, m_acc}) <<< 2;
        nacc = w[39:0]; cy = m_acc[38]; v = !in40(w); ov40 = v;
      end
      default: wr = 1'b0;
    endcase
    if (wr) begin
      m_acc = nacc; mz = (nacc == '0); mn = nacc[39]; mv = v; mc = cy;
      if (c == 5'd1) ms = 1'b0;
      else if (ov40) ms = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    logic [20:0] act, exp;
    act = {rd_data, flag_z, flag_n, flag_v, flag_c, flag_sticky};
    exp = {m_rd, mz, mn, mv, mc, ms};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd/z/n/v/c/s actual %h %b%b%b%b%b expected %h %b%b%b%b%b", req,
               act[20:5], act[4], act[3], act[2], act[1], act[0],
               exp[20:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic check_word(input string req, input logic [15:0] exp);
    n_vec++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data actual %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic issue(input logic [4:0] c, input logic s, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op = c; is_signed = s; opa = a; opb = b;
    model_step(c, s, a, b);
  endtask

  task automatic settle();
    @(negedge clk);
    op = 5'd0;
    @(negedge clk);
  endtask

  task automatic run(input logic [4:0] c, input logic s, input logic [15:0] a, input logic [15:0] b);
    issue(c, s, a, b);
    settle();
    check_all(req_of(c));
  endtask

  task automatic dump_state(input string req);
    run(5'd5, 1'b0, 16'h0, 16'h0);
    run(5'd6, 1'b0, 16'h0, 16'h0);
    run(5'd7, 1'b0, 16'h0, 16'h0);
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op = 5'd0; is_signed = 1'b0; opa = '0; opb = '0;
    m_acc = '0; m_rd = '0; mz = 1'b0; mn = 1'b0; mv = 1'b0; mc = 1'b0; ms = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");
    dump_state("R1");

    // R2: signed and unsigned products with literal expectations
    run(5'd2, 1'b1, 16'hFFFF, 16'hFFFF);
    run(5'd6, 1'b0, 0, 0); check_word("R2", 16'h0001);
    run(5'd2, 1'b0, 16'hFFFF, 16'hFFFF);
    run(5'd5, 1'b0, 0, 0); check_word("R2", 16'hFFFE);
    run(5'd7, 1'b0, 0, 0); check_word("R2", 16'h0000);
    run(5'd2, 1'b1, 16'h8000, 16'h0003);
    run(5'd7, 1'b0, 0, 0); check_word("R2", 16'hFFFF);

    // R3: back-to-back MAC
    run(5'd1, 1'b0, 0, 0);
    issue(5'd3, 1'b1, 16'd100, 16'd7);
    issue(5'd3, 1'b1, 16'hFFFE, 16'd50);
    issue(5'd3, 1'b0, 16'd3, 16'd3);
    settle();
    check_all("R3");
    run(5'd6, 1'b0, 0, 0); check_word("R3", 16'd609);

    // R7: save / restore of every field
    run(5'd9, 1'b0, 16'hA5C3, 0);
    run(5'd10, 1'b0, 16'h1234, 0);
    run(5'd11, 1'b0, 16'hFF9E, 0);
    dump_state("R7");
    run(5'd7, 1'b0, 0, 0); check_word("R7", 16'hFF9E);

    // R8 and R6: whole loads and fractional window
    run(5'd13, 1'b0, 16'hC001, 0);
    run(5'd8, 1'b0, 0, 0); check_word("R6", 16'hC001);
    run(5'd12, 1'b0, 16'h4321, 0); dump_state("R8");
    run(5'd14, 1'b0, 16'h8001, 16'h00FF); dump_state("R8");

    // R9: positive saturation, negative saturation, plain rounding
    run(5'd12, 1'b0, 16'h7FFF, 0);
    run(5'd10, 1'b0, 16'h8000, 0);
    run(5'd4, 1'b0, 0, 0);
    run(5'd5, 1'b0, 0, 0); check_word("R9", 16'h7FFF);
    run(5'd14, 1'b0, 16'h8000, 16'h0000);
    run(5'd11, 1'b0, 16'h0080, 0);
    run(5'd4, 1'b0, 0, 0);
    run(5'd5, 1'b0, 0, 0); check_word("R9", 16'h8000);
    run(5'd14, 1'b0, 16'h1234, 16'h8000);
    run(5'd4, 1'b0, 0, 0);
    run(5'd5, 1'b0, 0, 0); check_word("R9", 16'h1235);

    // R10: right shift of -1 stays -1
    run(5'd14, 1'b0, 16'hFFFF, 16'hFFFF);
    run(5'd15, 1'b0, 0, 0);
    run(5'd16, 1'b0, 0, 0);
    run(5'd6, 1'b0, 0, 0); check_word("R10", 16'hFFFF);

    // R12: sticky overflow held until clear; R11 flags on the way
    run(5'd11, 1'b0, 16'h007F, 0);
    run(5'd17, 1'b0, 0, 0);
    check_all("R12");
    run(5'd12, 1'b0, 16'h0001, 0);
    run(5'd4, 1'b0, 0, 0);
    run(5'd19, 1'b0, 16'hFFFF, 0);
    run(5'd31, 1'b0, 16'hFFFF, 0);
    check_all("R12");
    run(5'd1, 1'b0, 0, 0);
    check_all("R4");

    // random mix, checked against the model after each op
    for (int i = 0; i < 1500; i++) begin
      c = 5'($urandom_range(0, 22));
      if (c > 5'd18) c = (c == 5'd22) ? 5'd25 : 5'd3;
      run(c, 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom));
      if ((i % 50) == 49) dump_state("R11");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule